// File: doc/BRIEF.md
# Video Line and Pel Expansion Scheduler

This block sits between a frame store and a display path that scans a 480-line interlaced raster with 256 pixel slots per line. A configuration word sets the stored frame size, the pel depth, the screen window and the averaging options. From the raster strobes (field start with its parity, line start, and a per-slot pixel strobe), the block decides which stored frame line and which pel feed each slot. It also decides whether that slot shows a straight sample, a repeat, or a mean of two neighbours, and whether the slot is blanked.

The block issues two line indices and two word indices. The surrounding logic returns the four 16-bit words that those indices address. The block then unpacks the pels, forms any averages and registers the displayed 8-bit value. A sticky flag records that the forbidden combination of line repetition and vertical averaging was selected.

Top module: `vid_expand_sched`

## Requirements
- R1: After reset, pel_o is 0, blank_o is 1 and cfg_err_o is 0.
- R2: Configuration word layout: cfg_i[1:0] is the frame line count (00=60, 01=120, 10=240, 11 treated as 240), cfg_i[2] selects wide lines, cfg_i[3] selects 4-bit pels, cfg_i[4] enables horizontal averaging, cfg_i[5] enables vertical averaging, cfg_i[6] selects half width, and cfg_i[8:7] is the screen length (00=quarter, 01=half, 10 or 11=full). Field row r counts the line strobes since field start from 0. The active row count is R = 60, 120 or 240 for quarter, half or full length, and the frame line count is L. With no vertical averaging in force, row r shows frame line floor(r*L/R) in both field parities.
- R3: When L equals R and vertical averaging is on, the field with field_par_i=0 shows frame line r. The field with parity 1 shows the truncated mean of frame lines r and r+1, and the last row repeats line L-1.
- R4: When R equals 2L and vertical averaging is on, in either parity, even row r shows frame line r/2 and odd row r shows the mean of lines (r-1)/2 and (r+1)/2. The last odd row repeats line L-1. When both averagings apply, the horizontal mean is formed for each line first and the two results are then averaged.
- R5: When R equals 4L (60 lines, full length) with vertical averaging requested, the block shows plain repetition and cfg_err_o goes to 1 and stays at 1 until reset.
- R6: The active width W is 256 slots, or 128 at half width. A line holds P = 64 pels (8-bit, narrow), 128 pels, or 256 pels (4-bit, wide). When W is at least P, slot s shows pel floor(s*P/W), each pel held for W/P slots. Otherwise slot s shows pel 2s.
- R7: With horizontal averaging and a hold of two or more slots, the second half of each pel's hold shows the truncated mean of pel k and pel k+1. The last pel of a line repeats itself there.
- R8: 8-bit pel k sits in byte k mod 2 of word k/2, with byte 0 at bits 7:0. 4-bit pel k sits in nibble k mod 4 of word k/4, with nibble 0 at bits 3:0, and is shown as that nibble times 16. Averages are taken on these 8-bit values.
- R9: blank_o is 1 and pel_o is 0 for slots at or beyond W, for rows at or beyond R, and before the first line strobe of a field.
- R10: pel_o and blank_o show the slot addressed at a pix_en_i edge from that edge onward and do not change on cycles without pix_en_i. The first pixel strobe after a line strobe addresses slot 0.
- R11: For an active slot, the word indices stay below the words per line (32 narrow, 64 wide).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 9 | Configuration word (layout in R2) |
| field_start_i | input | 1 | Field start strobe |
| field_par_i | input | 1 | Parity of the starting field, sampled with field_start_i |
| line_start_i | input | 1 | Line start strobe |
| pix_en_i | input | 1 | Pixel slot strobe |
| line_a_o | output | 8 | Primary frame line index |
| line_b_o | output | 8 | Neighbour frame line index for vertical averaging |
| word_a_o | output | 6 | Word index holding the primary pel |
| word_b_o | output | 6 | Word index holding the neighbour pel |
| wd_aa_i | input | 16 | Word at line_a_o, word_a_o |
| wd_ab_i | input | 16 | Word at line_a_o, word_b_o |
| wd_ba_i | input | 16 | Word at line_b_o, word_a_o |
| wd_bb_i | input | 16 | Word at line_b_o, word_b_o |
| pel_o | output | 8 | Displayed value |
| blank_o | output | 1 | Slot is outside the screen window |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The frame store is a bench function whose words differ for every line and word index, so a wrong line, pel, byte lane or neighbour shows up as a wrong value. Fields run with both parities at 240 lines, with and without vertical averaging, which separates pure from averaged fields and exercises the last-row repeat. Further fields use 120 and 60 lines with doubled rows, pel holds of 1, 2 and 4 slots, and row and pel decimation. A 4-bit half-width case checks nibble unpacking, and the illegal 60-line full-length case checks the fallback and the sticky flag. Slots and rows past the window, and slots before the first line strobe, test blanking.

// File: rtl/vxs_pkg.sv
package vxs_pkg;

    typedef struct packed {
        logic [1:0] len;
        logic       hwin;
        logic       vavg;
        logic       havg;
        logic       nib;
        logic       wide;
        logic [1:0] lines;
    } vxs_cfg_t;

    // Pull one pel out of a packed word; 4-bit pels are scaled to 8 bits.
    function automatic logic [7:0] pick_pel(input logic [15:0] w,
                                            input logic [1:0]  k,
                                            input logic        nib);
        logic [3:0] n;
        if (nib) begin
            n = w[4*k +: 4];
            return {n, 4'b0000};
        end
        return k[0] ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/vxs_raster.sv
module vxs_raster #(
    parameter int ROW_W  = 9,
    parameter int SLOT_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              field_start_i,
    input  logic              field_par_i,
    input  logic              line_start_i,
    input  logic              pix_en_i,
    output logic              par_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [ROW_W-1:0]  ROW_IDLE  = '1;
    localparam logic [ROW_W-1:0]  ROW_TOP   = ROW_IDLE - 1'b1;
    localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;

    typedef struct packed {
        logic              par;
        logic [ROW_W-1:0]  row;
        logic [SLOT_W-1:0] slot;
    } rst_t;

    rst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (field_start_i) begin
            s_d.par  = field_par_i;
            s_d.row  = ROW_IDLE;
            s_d.slot = SLOT_IDLE;
        end else if (line_start_i) begin
            if (s_q.row != ROW_TOP) s_d.row = s_q.row + 1'b1;
            s_d.slot = '0;
        end else if (pix_en_i && s_q.slot != SLOT_IDLE) begin
            s_d.slot = s_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{par: 1'b0, row: ROW_IDLE, slot: SLOT_IDLE};
        else         s_q <= s_d;
    end

    assign par_o  = s_q.par;
    assign row_o  = s_q.row;
    assign slot_o = s_q.slot;

endmodule

// File: rtl/vxs_vmap.sv
module vxs_vmap #(
    parameter int ROW_W  = 9,
    parameter int LINE_W = 8
) (
    input  logic [1:0]        lines_i,
    input  logic [1:0]        len_i,
    input  logic              vavg_i,
    input  logic              par_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic [LINE_W-1:0] line_a_o,
    output logic [LINE_W-1:0] line_b_o,
    output logic              vmix_o,
    output logic              row_act_o,
    output logic              bad_o
);
    localparam logic [ROW_W-1:0] BASE_ROWS = ROW_W'(60);

    logic [1:0]       lc, nc;
    logic [ROW_W-1:0] base, last;

    always_comb begin
        lc        = (len_i == 2'd3) ? 2'd2 : len_i;
        nc        = (lines_i == 2'd3) ? 2'd2 : lines_i;
        last      = (BASE_ROWS << nc) - 1'b1;
        row_act_o = row_i < (BASE_ROWS << lc);
        bad_o     = vavg_i && lc == 2'd2 && nc == 2'd0;
        if (lc >= nc) base = row_i >> (lc - nc);
        else          base = row_i << (nc - lc);
        line_a_o = LINE_W'(base);
        line_b_o = LINE_W'(base);
        vmix_o   = 1'b0;
        if (vavg_i && lc == nc && par_i && base != last) begin
            line_b_o = LINE_W'(base + 1'b1);
            vmix_o   = 1'b1;
        end
        if (vavg_i && {1'b0, lc} == {1'b0, nc} + 3'd1 && row_i[0] && base != last) begin
            line_b_o = LINE_W'(base + 1'b1);
            vmix_o   = 1'b1;
        end
    end

endmodule

// File: rtl/vxs_hmap.sv
module vxs_hmap #(
    parameter int SLOT_W = 9,
    parameter int PEL_W  = 8,
    parameter int WORD_W = 6
) (
    input  logic              wide_i,
    input  logic              nib_i,
    input  logic              havg_i,
    input  logic              hwin_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [PEL_W-1:0]  ka_o,
    output logic [PEL_W-1:0]  kb_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o,
    output logic              hmix_o,
    output logic              slot_act_o
);
    localparam int          FULL_SLOTS = 1 << PEL_W;
    localparam logic [3:0]  LOG_MIN    = 4'd6;

    logic [3:0]       lp, lw, d;
    logic [PEL_W-1:0] s8, last;
    logic [PEL_W:0]   pc;
    logic             hi;

    always_comb begin
        lp         = LOG_MIN + {3'b0, wide_i} + {3'b0, nib_i};
        lw         = hwin_i ? 4'd7 : 4'd8;
        slot_act_o = slot_i < SLOT_W'(hwin_i ? FULL_SLOTS / 2 : FULL_SLOTS);
        s8         = slot_i[PEL_W-1:0];
        pc         = (PEL_W+1)'(1) << lp;
        last       = PEL_W'(pc - 1'b1);
        d          = (lw >= lp) ? lw - lp : 4'd0;
        ka_o       = (lw >= lp) ? (s8 >> d) : (s8 << 1);
        case (d)
            4'd1:    hi = s8[0];
            4'd2:    hi = s8[1];
            default: hi = 1'b0;
        endcase
        hmix_o   = havg_i && hi && ka_o != last;
        kb_o     = hmix_o ? ka_o + 1'b1 : ka_o;
        word_a_o = nib_i ? WORD_W'(ka_o >> 2) : WORD_W'(ka_o >> 1);
        word_b_o = nib_i ? WORD_W'(kb_o >> 2) : WORD_W'(kb_o >> 1);
    end

endmodule

// File: rtl/vxs_blend.sv
module vxs_blend
    import vxs_pkg::*;
#(
    parameter int PEL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pix_en_i,
    input  logic             blank_i,
    input  logic             nib_i,
    input  logic             hmix_i,
    input  logic             vmix_i,
    input  logic [1:0]       ka_i,
    input  logic [1:0]       kb_i,
    input  logic [15:0]      wd_aa_i,
    input  logic [15:0]      wd_ab_i,
    input  logic [15:0]      wd_ba_i,
    input  logic [15:0]      wd_bb_i,
    output logic [PEL_W-1:0] pel_o,
    output logic             blank_o
);
    typedef struct packed {
        logic [PEL_W-1:0] pel;
        logic             blank;
    } out_t;

    out_t o_d, o_q;
    logic [PEL_W-1:0] a0, a1, b0, b1, ha, hb, vv;
    logic [PEL_W:0]   sa, sb, sv;

    always_comb begin
        a0 = pick_pel(wd_aa_i, ka_i, nib_i);
        a1 = pick_pel(wd_ab_i, kb_i, nib_i);
        b0 = pick_pel(wd_ba_i, ka_i, nib_i);
        b1 = pick_pel(wd_bb_i, kb_i, nib_i);
        sa = {1'b0, a0} + {1'b0, a1};
        sb = {1'b0, b0} + {1'b0, b1};
        ha = hmix_i ? sa[PEL_W:1] : a0;
        hb = hmix_i ? sb[PEL_W:1] : b0;
        sv = {1'b0, ha} + {1'b0, hb};
        vv = vmix_i ? sv[PEL_W:1] : ha;
        o_d = o_q;
        if (pix_en_i) begin
            o_d.blank = blank_i;
            o_d.pel   = blank_i ? '0 : vv;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '{pel: '0, blank: 1'b1};
        else         o_q <= o_d;
    end

    assign pel_o   = o_q.pel;
    assign blank_o = o_q.blank;

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pix_en_i |=> $stable(o_q.pel) && $stable(o_q.blank)); // R10

endmodule

// File: rtl/vid_expand_sched.sv
module vid_expand_sched
    import vxs_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int SLOT_W = 9,
    parameter int LINE_W = 8,
    parameter int PEL_W  = 8,
    parameter int WORD_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [8:0]        cfg_i,
    input  logic              field_start_i,
    input  logic              field_par_i,
    input  logic              line_start_i,
    input  logic              pix_en_i,
    output logic [LINE_W-1:0] line_a_o,
    output logic [LINE_W-1:0] line_b_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o,
    input  logic [15:0]       wd_aa_i,
    input  logic [15:0]       wd_ab_i,
    input  logic [15:0]       wd_ba_i,
    input  logic [15:0]       wd_bb_i,
    output logic [PEL_W-1:0]  pel_o,
    output logic              blank_o,
    output logic              cfg_err_o
);
    localparam logic [WORD_W:0] WORDS_WIDE = (WORD_W+1)'(1) << WORD_W;

    vxs_cfg_t          cfg;
    logic              par, vmix, hmix, row_act, slot_act, bad;
    logic [ROW_W-1:0]  row;
    logic [SLOT_W-1:0] slot;
    logic [PEL_W-1:0]  ka, kb;
    logic              err_d, err_q;

    assign cfg = vxs_cfg_t'(cfg_i);

    vxs_raster #(.ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_raster (
        .clk_i(clk_i), .rst_ni(rst_ni), .field_start_i(field_start_i),
        .field_par_i(field_par_i), .line_start_i(line_start_i), .pix_en_i(pix_en_i),
        .par_o(par), .row_o(row), .slot_o(slot));

    vxs_vmap #(.ROW_W(ROW_W), .LINE_W(LINE_W)) u_vmap (
        .lines_i(cfg.lines), .len_i(cfg.len), .vavg_i(cfg.vavg), .par_i(par),
        .row_i(row), .line_a_o(line_a_o), .line_b_o(line_b_o), .vmix_o(vmix),
        .row_act_o(row_act), .bad_o(bad));

    vxs_hmap #(.SLOT_W(SLOT_W), .PEL_W(PEL_W), .WORD_W(WORD_W)) u_hmap (
        .wide_i(cfg.wide), .nib_i(cfg.nib), .havg_i(cfg.havg), .hwin_i(cfg.hwin),
        .slot_i(slot), .ka_o(ka), .kb_o(kb), .word_a_o(word_a_o), .word_b_o(word_b_o),
        .hmix_o(hmix), .slot_act_o(slot_act));

    vxs_blend #(.PEL_W(PEL_W)) u_blend (
        .clk_i(clk_i), .rst_ni(rst_ni), .pix_en_i(pix_en_i),
        .blank_i(!(row_act && slot_act)), .nib_i(cfg.nib), .hmix_i(hmix), .vmix_i(vmix),
        .ka_i(ka[1:0]), .kb_i(kb[1:0]), .wd_aa_i(wd_aa_i), .wd_ab_i(wd_ab_i),
        .wd_ba_i(wd_ba_i), .wd_bb_i(wd_bb_i), .pel_o(pel_o), .blank_o(blank_o));

    always_comb begin
        err_d = err_q | bad;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= err_d;
    end

    assign cfg_err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o); // R5
    AST_BAD_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad |-> !vmix && line_a_o == line_b_o); // R5
    AST_ROWS_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_en_i && !row_act |=> blank_o && pel_o == '0); // R9
    AST_VMIX_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vmix |-> line_b_o == line_a_o + 1'b1); // R4
    AST_WORD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_act && slot_act && !cfg.wide |-> {1'b0, word_a_o} < (WORDS_WIDE >> 1)
            && {1'b0, word_b_o} < (WORDS_WIDE >> 1)); // R11

endmodule

// File: tb/sim_vid_expand_sched.sv
`timescale 1ns/1ps
module sim_vid_expand_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cfg = '0;
    logic        fs = 1'b0, fpar = 1'b0, ls = 1'b0, pix = 1'b0;
    logic [7:0]  line_a, line_b, pel;
    logic [5:0]  word_a, word_b;
    logic [15:0] wd_aa, wd_ab, wd_ba, wd_bb;
    logic        blank, err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int rowc = -1;

    always #2.5 clk = ~clk;

    vid_expand_sched u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .field_start_i(fs),
        .field_par_i(fpar), .line_start_i(ls), .pix_en_i(pix),
        .line_a_o(line_a), .line_b_o(line_b), .word_a_o(word_a), .word_b_o(word_b),
        .wd_aa_i(wd_aa), .wd_ab_i(wd_ab), .wd_ba_i(wd_ba), .wd_bb_i(wd_bb),
        .pel_o(pel), .blank_o(blank), .cfg_err_o(err));

    function automatic logic [15:0] mem16(input int l, input int w);
        return 16'((l * 97 + w * 53 + 13) ^ (w << 9) ^ (l << 5));
    endfunction

    always_comb begin
        wd_aa = mem16(int'(line_a), int'(word_a));
        wd_ab = mem16(int'(line_a), int'(word_b));
        wd_ba = mem16(int'(line_b), int'(word_a));
        wd_bb = mem16(int'(line_b), int'(word_b));
    end

    function automatic int pel_of(input int l, input int k, input bit nib);
        int w;
        w = int'(mem16(l, nib ? k / 4 : k / 2));
        if (nib) return ((w >> (4 * (k % 4))) & 15) * 16;
        return (w >> (8 * (k % 2))) & 255;
    endfunction

    function automatic logic [8:0] mk(input int lines, input bit wide, input bit nib,
                                      input bit havg, input bit vavg, input bit hw,
                                      input int len);
        return {2'(len), hw, vavg, havg, nib, wide, 2'(lines)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference for one slot.
    task automatic ref_px(input int par, input int r, input int s,
                          output int exp, output bit blk);
        int lines, len, rr, ll, ww, pp, hold, a, b, k, k2, ha, hb;
        bit wide, nib, havg, vavg, hw;
        lines = (cfg[1:0] == 2'd3) ? 2 : int'(cfg[1:0]);
        len   = (cfg[8:7] == 2'd3) ? 2 : int'(cfg[8:7]);
        wide = cfg[2]; nib = cfg[3]; havg = cfg[4]; vavg = cfg[5]; hw = cfg[6];
        rr = 60 * (1 << len); ll = 60 * (1 << lines);
        ww = hw ? 128 : 256;
        pp = (wide ? 128 : 64) * (nib ? 2 : 1);
        exp = 0; blk = 1'b1;
        if (r < 0 || r >= rr || s >= ww) return;
        blk = 1'b0;
        if (vavg && rr == ll) begin
            a = r; b = (par == 1) ? ((r + 1 < ll) ? r + 1 : ll - 1) : r;
        end else if (vavg && rr == 2 * ll) begin
            a = r / 2; b = (r % 2 == 1) ? ((a + 1 < ll) ? a + 1 : ll - 1) : a;
        end else begin
            a = r * ll / rr; b = a;
        end
        if (ww >= pp) begin
            hold = ww / pp; k = s / hold; k2 = k;
            if (havg && hold >= 2 && (s % hold) >= hold / 2 && k < pp - 1) k2 = k + 1;
        end else begin
            k = s * pp / ww; k2 = k;
        end
        ha = (pel_of(a, k, nib) + pel_of(a, k2, nib)) / 2;
        hb = (pel_of(b, k, nib) + pel_of(b, k2, nib)) / 2;
        exp = (ha + hb) / 2;
    endtask

    task automatic cmp(input int exp, input bit blk, input string req);
        if (blk) check(blank === 1'b1 && pel === 8'd0, "R9", int'(pel), 0);
        else     check(blank === 1'b0 && int'(pel) == exp, req, int'(pel), exp);
    endtask

    task automatic pix_run(input int par, input int n, input string req);
        int exp, pexp;
        bit blk, pblk;
        pexp = 0; pblk = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) cmp(pexp, pblk, req);
            pix = 1'b1;
            ref_px(par, rowc, i, exp, blk);
            if (!blk) check(int'(word_a) < (cfg[2] ? 64 : 32) && int'(word_b) < (cfg[2] ? 64 : 32),
                            "R11", int'(word_b), cfg[2] ? 63 : 31);
            pexp = exp; pblk = blk;
        end
        @(negedge clk);
        pix = 1'b0;
        cmp(pexp, pblk, req);
    endtask

    task automatic line_pulse();
        logic [7:0] held;
        @(negedge clk);
        held = pel;
        ls = 1'b1;
        @(negedge clk);
        ls = 1'b0;
        check(pel === held, "R10", int'(pel), int'(held));
        rowc++;
    endtask

    task automatic run_field(input logic [8:0] c, input int par, input string req);
        int rr;
        @(negedge clk);
        cfg = c; fs = 1'b1; fpar = 1'(par);
        @(negedge clk);
        fs = 1'b0;
        rowc = -1;
        pix_run(par, 3, "R9");
        rr = 60 * (1 << ((c[8:7] == 2'd3) ? 2 : int'(c[8:7])));
        for (int r = 0; r < rr + 2; r++) begin
            line_pulse();
            if (r < 3 || r >= rr - 3 || r % 23 == 11) pix_run(par, 260, req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pel === 8'd0, "R1", int'(pel), 0);
        check(blank === 1'b1, "R1", int'(blank), 1);
        check(err === 1'b0, "R1", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pel === 8'd0 && blank === 1'b1 && err === 1'b0, "R1", int'(blank), 1);

        run_field(mk(2, 1, 0, 0, 0, 0, 2), 0, "R2");
        run_field(mk(2, 1, 0, 0, 0, 0, 2), 1, "R2");
        run_field(mk(2, 1, 0, 0, 1, 0, 2), 0, "R3");
        run_field(mk(2, 1, 0, 0, 1, 0, 2), 1, "R3");
        run_field(mk(1, 1, 0, 0, 1, 0, 2), 1, "R4");
        run_field(mk(0, 0, 0, 1, 1, 0, 1), 0, "R4");
        run_field(mk(1, 0, 1, 0, 0, 1, 2), 0, "R8");
        run_field(mk(2, 1, 0, 1, 0, 0, 1), 1, "R7");
        run_field(mk(0, 0, 0, 1, 0, 0, 2), 0, "R7");
        run_field(mk(1, 1, 1, 0, 0, 1, 0), 0, "R6");
        check(err === 1'b0, "R5", int'(err), 0);
        run_field(mk(0, 1, 1, 0, 1, 0, 2), 1, "R5");
        check(err === 1'b1, "R5", int'(err), 1);
        @(negedge clk);
        cfg = mk(2, 1, 0, 0, 0, 0, 2);
        repeat (4) @(negedge clk);
        check(err === 1'b1, "R5", int'(err), 1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule